// File: doc/BRIEF.md
# Command-Driven Power and Reset Sequencer

This block sits behind a write-only command register in a system controller. A host write carries a five-bit command. The bits can ask the block to power the system off, to start a full reboot that also wipes the preserved boot-environment state, or to start a normal reboot that keeps that state. A bit can also ask for a reset of the external memory alone, and another can announce that the system is about to enter sleep. The block drives three active-low reset lines: one for the system, one for a secondary domain and one for the external memory. A separate strobe puts the system into a halted state in which the system reset never releases.

After an accepted reset command, the block pulls the selected lines low and keeps them there for a hold interval. It then releases all of them on the same edge. After a longer settle interval it raises a one-cycle request to reinitialise the surrounding registers. Both intervals are counted in ticks of an internal prescaler. The prescaler restarts on every accepted command, so each interval is an exact number of clock cycles. The block has two resets. The ordinary hardware reset clears every state except the halted state. Only the power-on reset leaves the halted state.

Top module: `pwr_reset_seq`

## Requirements
- R1: After the hardware reset, all three reset lines are high, and `busy`, `power_off`, `clr_bootenv`, `sleep_pulse` and `reinit_req` are low.
- R2: Command bit 2 (normal reboot) pulls `sys_rst_n` and `sec_rst_n` low. It pulls `mem_rst_n` low only if `emu_mode` is high in the write cycle. Later changes of `emu_mode` have no effect on a sequence that is already running.
- R3: Command bit 1 (full reboot) pulls all three lines low. It also raises `clr_bootenv` for the one cycle after the accepting edge. A write without bit 1 never raises `clr_bootenv`.
- R4: Command bit 3 (memory reset) pulls only `mem_rst_n` low.
- R5: When several of bits 1 to 3 are set in one write, the asserted lines are the union of the lines each bit selects. Bit 4 adds no reset line.
- R6: The selected lines go low on the edge that accepts the write. They stay low for exactly HOLD_TICKS*CLKS_PER_TICK cycles, and all of them rise on the same edge.
- R7: `reinit_req` is high for exactly one cycle. It rises REINIT_TICKS*CLKS_PER_TICK cycles after the release, and `busy` falls on that same edge. `busy` is high from the accepting edge until then.
- R8: Command bit 0 (power-off) takes precedence over bits 1 to 3 in the same write. It sets `power_off` and holds it until a hardware reset, and it starts no reset sequence.
- R9: Command bit 4 raises `sleep_pulse` for one cycle and then clears it. A write whose bits 0 to 3 are all zero starts no sequence.
- R10: A write is ignored while `busy`, `power_off` or `halted` is high. An ignored write changes no line and starts no later sequence.
- R11: A `kill_wr` strobe sets `halted` and holds `sys_rst_n` low. The hardware reset does not clear this state; only `por_n` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low; leaves the halted state alone |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears everything including the halted state |
| cmd_wr | input | 1 | Write strobe for the command register, one cycle per write |
| cmd_data | input | 5 | Command bits: 0 power-off, 1 full reboot, 2 normal reboot, 3 memory reset, 4 sleep notice |
| kill_wr | input | 1 | Strobe that enters the halted state |
| emu_mode | input | 1 | Emulation mode; adds the memory reset to a normal reboot |
| sys_rst_n | output | 1 | System reset, active low |
| sec_rst_n | output | 1 | Secondary reset, active low |
| mem_rst_n | output | 1 | External memory reset, active low |
| power_off | output | 1 | Power-off request, held high once set |
| clr_bootenv | output | 1 | One-cycle pulse to clear boot-environment state |
| sleep_pulse | output | 1 | One-cycle sleep notice |
| reinit_req | output | 1 | One-cycle request to reinitialise registers |
| busy | output | 1 | A reset sequence is running |
| halted | output | 1 | The halted (kill) state is active |

## Verification
The assertions assume that both resets are asserted together at power-up and that `por_n` stays high for as long as they check the halted state. They assume that `cmd_wr` and `kill_wr` are plain strobes sampled on the rising edge, and they rely on no particular spacing between writes. The stimulus drives every input half a cycle away from the active edge. It asserts `por_n` only at the start and in the final halted-state test. It includes stray writes in the middle of running sequences and changes `emu_mode` there as well, so the checks cover the cases where the block must ignore its inputs.

// File: rtl/pwr_reset_seq_pkg.sv
package pwr_reset_seq_pkg;
  localparam int CMD_W   = 5;
  localparam int LINE_N  = 3;
  localparam int B_OFF   = 0;
  localparam int B_FULL  = 1;
  localparam int B_NORM  = 2;
  localparam int B_MEM   = 3;
  localparam int B_SLEEP = 4;
  localparam int L_SYS   = 0;
  localparam int L_SEC   = 1;
  localparam int L_MEM   = 2;

  typedef enum logic [1:0] {PH_IDLE, PH_HOLD, PH_WAIT} phase_e;

  typedef struct packed {
    logic              off;
    logic              seq;
    logic              clr;
    logic              sleep;
    logic [LINE_N-1:0] lines;
  } cmd_req_t;
endpackage

// File: rtl/pwr_reset_seq_decode.sv
module pwr_reset_seq_decode
  import pwr_reset_seq_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             emu_i,
  output cmd_req_t         req_o
);
  logic [LINE_N-1:0] sel;

  always_comb begin
    sel        = '0;
    sel[L_SYS] = cmd_i[B_FULL] | cmd_i[B_NORM];
    sel[L_SEC] = cmd_i[B_FULL] | cmd_i[B_NORM];
    sel[L_MEM] = cmd_i[B_FULL] | cmd_i[B_MEM] | (cmd_i[B_NORM] & emu_i);
  end

  always_comb begin
    req_o.off   = cmd_i[B_OFF];
    req_o.lines = cmd_i[B_OFF] ? '0 : sel;
    req_o.seq   = ~cmd_i[B_OFF] & (|sel);
    req_o.clr   = ~cmd_i[B_OFF] & cmd_i[B_FULL];
    req_o.sleep = cmd_i[B_SLEEP];
  end
endmodule

// File: rtl/pwr_reset_seq_timer.sv
module pwr_reset_seq_timer
  import pwr_reset_seq_pkg::*;
#(
  parameter int CLKS_PER_TICK = 50000,
  parameter int HOLD_TICKS    = 5,
  parameter int REINIT_TICKS  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic release_o,
  output logic reinit_o,
  output logic busy_o
);
  localparam int PRE_W   = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
  localparam int MAX_T   = (HOLD_TICKS > REINIT_TICKS) ? HOLD_TICKS : REINIT_TICKS;
  localparam int CNT_W   = $clog2(MAX_T + 1);
  localparam logic [PRE_W-1:0] PRE_LAST  = PRE_W'(CLKS_PER_TICK - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_TICKS - 1);
  localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(REINIT_TICKS - 1);

  phase_e           phase_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;
  logic             hold_end;
  logic             wait_end;
  logic             reinit_q;

  assign tick     = (phase_q != PH_IDLE) && (pre_q == PRE_LAST);
  assign hold_end = tick && (phase_q == PH_HOLD) && (cnt_q == HOLD_LAST);
  assign wait_end = tick && (phase_q == PH_WAIT) && (cnt_q == WAIT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      pre_q    <= '0;
      cnt_q    <= '0;
      reinit_q <= 1'b0;
    end else begin
      reinit_q <= wait_end;
      if (start_i && phase_q == PH_IDLE) begin
        phase_q <= PH_HOLD;
        pre_q   <= '0;
        cnt_q   <= '0;
      end else if (phase_q != PH_IDLE) begin
        pre_q <= tick ? '0 : pre_q + 1'b1;
        if (hold_end) begin
          phase_q <= PH_WAIT;
          cnt_q   <= '0;
        end else if (wait_end) begin
          phase_q <= PH_IDLE;
          cnt_q   <= '0;
        end else if (tick) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign release_o = hold_end;
  assign reinit_o  = reinit_q;
  assign busy_o    = (phase_q != PH_IDLE);
endmodule

// File: rtl/pwr_reset_seq_lines.sv
module pwr_reset_seq_lines
  import pwr_reset_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              start_i,
  input  logic [LINE_N-1:0] sel_i,
  input  logic              release_i,
  input  logic              kill_i,
  output logic [LINE_N-1:0] line_n_o,
  output logic              halted_o
);
  logic [LINE_N-1:0] act_q;
  logic              halt_q;

  for (genvar g = 0; g < LINE_N; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              act_q[g] <= 1'b0;
      else if (release_i)      act_q[g] <= 1'b0;
      else if (start_i)        act_q[g] <= sel_i[g];
    end
    if (g == L_SYS) begin : g_sys
      assign line_n_o[g] = ~(act_q[g] | halt_q);
    end else begin : g_other
      assign line_n_o[g] = ~act_q[g];
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      halt_q <= 1'b0;
    else if (kill_i) halt_q <= 1'b1;
  end

  assign halted_o = halt_q;
endmodule

// File: rtl/pwr_reset_seq.sv
module pwr_reset_seq
  import pwr_reset_seq_pkg::*;
#(
  parameter int CLKS_PER_TICK = 50000,
  parameter int HOLD_TICKS    = 5,
  parameter int REINIT_TICKS  = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_n,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_data,
  input  logic             kill_wr,
  input  logic             emu_mode,
  output logic             sys_rst_n,
  output logic             sec_rst_n,
  output logic             mem_rst_n,
  output logic             power_off,
  output logic             clr_bootenv,
  output logic             sleep_pulse,
  output logic             reinit_req,
  output logic             busy,
  output logic             halted
);
  cmd_req_t          req;
  logic              accept;
  logic              seq_start;
  logic              rel;
  logic              busy_w;
  logic              halt_w;
  logic [LINE_N-1:0] line_n;
  logic              off_q;
  logic              clr_q;
  logic              sleep_q;
  logic              hw_rst_n;

  assign hw_rst_n = rst_n & por_n;

  pwr_reset_seq_decode u_dec (
    .cmd_i (cmd_data),
    .emu_i (emu_mode),
    .req_o (req)
  );

  assign accept    = cmd_wr & ~busy_w & ~halt_w & ~off_q;
  assign seq_start = accept & req.seq;

  pwr_reset_seq_timer #(
    .CLKS_PER_TICK (CLKS_PER_TICK),
    .HOLD_TICKS    (HOLD_TICKS),
    .REINIT_TICKS  (REINIT_TICKS)
  ) u_tmr (
    .clk       (clk),
    .rst_n     (hw_rst_n),
    .start_i   (seq_start),
    .release_o (rel),
    .reinit_o  (reinit_req),
    .busy_o    (busy_w)
  );

  pwr_reset_seq_lines u_lines (
    .clk       (clk),
    .rst_n     (hw_rst_n),
    .por_n     (por_n),
    .start_i   (seq_start),
    .sel_i     (req.lines),
    .release_i (rel),
    .kill_i    (kill_wr),
    .line_n_o  (line_n),
    .halted_o  (halt_w)
  );

  always_ff @(posedge clk or negedge hw_rst_n) begin
    if (!hw_rst_n) begin
      off_q   <= 1'b0;
      clr_q   <= 1'b0;
      sleep_q <= 1'b0;
    end else begin
      if (accept && req.off) off_q <= 1'b1;
      clr_q   <= seq_start & req.clr;
      sleep_q <= accept & req.sleep;
    end
  end

  assign sys_rst_n   = line_n[L_SYS];
  assign sec_rst_n   = line_n[L_SEC];
  assign mem_rst_n   = line_n[L_MEM];
  assign power_off   = off_q;
  assign clr_bootenv = clr_q;
  assign sleep_pulse = sleep_q;
  assign busy        = busy_w;
  assign halted      = halt_w;
endmodule

// File: rtl/pwr_reset_seq_chk.sv
module pwr_reset_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       por_n,
  input logic       cmd_wr,
  input logic [4:0] cmd_data,
  input logic       kill_wr,
  input logic       emu_mode,
  input logic       sys_rst_n,
  input logic       sec_rst_n,
  input logic       mem_rst_n,
  input logic       power_off,
  input logic       clr_bootenv,
  input logic       sleep_pulse,
  input logic       reinit_req,
  input logic       busy,
  input logic       halted
);
  assert_clr_full_R3: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (clr_bootenv && !halted) |-> (!sys_rst_n && !sec_rst_n && !mem_rst_n && busy));

  assert_release_together_R6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (!halted && ($rose(sys_rst_n) || $rose(sec_rst_n) || $rose(mem_rst_n)))
      |-> (sys_rst_n && sec_rst_n && mem_rst_n));

  assert_reinit_single_R7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    reinit_req |=> !reinit_req);

  assert_reinit_idle_R7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    reinit_req |-> (!busy && $fell(busy)));

  assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (power_off && !halted) |-> (sys_rst_n && sec_rst_n && mem_rst_n && !busy));

  assert_sleep_single_R9: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    sleep_pulse |=> !sleep_pulse);

  assert_start_from_idle_R10: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    ($fell(sec_rst_n) || $fell(mem_rst_n)) |-> $rose(busy));

  assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!por_n)
    halted |=> halted);

  assert_halt_sys_R11: assert property (@(posedge clk) disable iff (!por_n)
    halted |-> !sys_rst_n);
endmodule

bind pwr_reset_seq pwr_reset_seq_chk chk_i (.*);

// File: tb/pwr_reset_seq_tb_top.sv
module pwr_reset_seq_tb_top;
  localparam int CPT  = 4;
  localparam int HT   = 5;
  localparam int RT   = 20;
  localparam int HC   = HT * CPT;
  localparam int TOT  = (HT + RT) * CPT;

  logic       clk = 1'b0;
  logic       rst_n, por_n, cmd_wr, kill_wr, emu_mode;
  logic [4:0] cmd_data;
  logic       sys_rst_n, sec_rst_n, mem_rst_n, power_off, clr_bootenv;
  logic       sleep_pulse, reinit_req, busy, halted;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pwr_reset_seq #(.CLKS_PER_TICK(CPT), .HOLD_TICKS(HT), .REINIT_TICKS(RT)) dut_i (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .kill_wr(kill_wr), .emu_mode(emu_mode), .sys_rst_n(sys_rst_n), .sec_rst_n(sec_rst_n),
    .mem_rst_n(mem_rst_n), .power_off(power_off), .clr_bootenv(clr_bootenv),
    .sleep_pulse(sleep_pulse), .reinit_req(reinit_req), .busy(busy), .halted(halted)
  );

  // asserted-line view: bit0 system, bit1 secondary, bit2 memory
  function automatic logic [2:0] exp_lines(input logic [4:0] c, input logic emu);
    logic [2:0] m;
    m = '0;
    if (c[1]) m = 3'b111;
    if (c[2]) m = m | 3'b011 | (emu ? 3'b100 : 3'b000);
    if (c[3]) m = m | 3'b100;
    if (c[0]) m = '0;
    return m;
  endfunction

  function automatic logic [2:0] act_lines();
    return {~mem_rst_n, ~sec_rst_n, ~sys_rst_n};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cmd(input logic [4:0] c, input logic emu);
    @(negedge clk);
    emu_mode = emu; cmd_data = c; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic run_seq(input logic [4:0] c, input logic emu, input string req);
    logic [2:0] m;
    bit seq;
    int hold_bad, rel_bad, re_at, re_cnt, after_bad;
    m   = exp_lines(c, emu);
    seq = (m != 0);
    write_cmd(c, emu);
    chk({req, " lines at accept"}, int'(act_lines()), int'(m));
    chk("R3 clr_bootenv pulse", int'(clr_bootenv), int'(seq && c[1]));
    chk("R9 sleep pulse", int'(sleep_pulse), int'(c[4]));
    chk("R7 busy at accept", int'(busy), int'(seq));
    if (seq) begin
      hold_bad = 0; rel_bad = 0; re_at = -1; re_cnt = 0; after_bad = 0;
      for (int k = 1; k <= TOT + 3; k++) begin
        @(negedge clk);
        if (k == 3) begin
          cmd_wr = 1'b1; cmd_data = 5'($urandom); emu_mode = ~emu;
        end
        if (k == 4) cmd_wr = 1'b0;
        if (k < HC && act_lines() != m) hold_bad++;
        if (k >= HC && act_lines() != 3'b000) rel_bad++;
        if (k == 1 && (clr_bootenv || sleep_pulse)) hold_bad++;
        if (reinit_req) begin
          re_cnt++;
          if (re_at < 0) re_at = k;
        end
        if (k < TOT && !busy) hold_bad++;
        if (k >= TOT && busy) after_bad++;
      end
      chk("R6 lines held for hold interval (R2 emu sampled once)", hold_bad, 0);
      chk("R6 all released together and stay released", rel_bad, 0);
      chk("R7 reinit position", re_at, TOT);
      chk("R7 reinit single cycle", re_cnt, 1);
      chk("R10 stray write started nothing", after_bad, 0);
    end else begin
      @(negedge clk);
      chk("R9 no sequence without reset bits", int'({busy, act_lines()}), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; por_n = 1'b0; cmd_wr = 1'b0; kill_wr = 1'b0;
    emu_mode = 1'b0; cmd_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    @(negedge clk);
    chk("R1 lines idle", int'(act_lines()), 0);
    chk("R1 flags idle", int'({busy, power_off, clr_bootenv, sleep_pulse, reinit_req, halted}), 0);

    run_seq(5'b00100, 1'b0, "R2 normal no emu");
    run_seq(5'b00100, 1'b1, "R2 normal emu");
    run_seq(5'b00010, 1'b0, "R3 full");
    run_seq(5'b01000, 1'b1, "R4 memory only");
    run_seq(5'b11100, 1'b0, "R5 union");
    run_seq(5'b10000, 1'b1, "R9 sleep only");
    run_seq(5'b00000, 1'b0, "R9 empty");
    for (int i = 0; i < 24; i++) begin
      logic [4:0] c;
      c = 5'($urandom) & 5'b11110;
      run_seq(c, 1'($urandom), "R5 random");
    end

    write_cmd(5'b00111, 1'b1);
    chk("R8 power_off set", int'(power_off), 1);
    chk("R8 no lines on power-off", int'({busy, act_lines()}), 0);
    write_cmd(5'b00100, 1'b0);
    repeat (3) @(negedge clk);
    chk("R10 write ignored after power-off", int'({busy, act_lines()}), 0);
    chk("R8 power_off held", int'(power_off), 1);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk("R8 power_off cleared by reset", int'(power_off), 0);

    @(negedge clk); kill_wr = 1'b1; @(negedge clk); kill_wr = 1'b0;
    chk("R11 halted set", int'(halted), 1);
    chk("R11 sys low", int'(sys_rst_n), 0);
    write_cmd(5'b01000, 1'b0);
    chk("R10 write ignored when halted", int'({busy, mem_rst_n}), 1);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk("R11 halted survives hardware reset", int'({halted, sys_rst_n}), 2);
    por_n = 1'b0; @(negedge clk); por_n = 1'b1; @(negedge clk);
    chk("R11 power-on reset clears halted", int'({halted, sys_rst_n}), 1);
    run_seq(5'b00010, 1'b0, "R3 full after power-on");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule